// File: doc/BRIEF.md
# Dual-Channel Serial Register Interface

This block is the host-side register front end of a two-channel asynchronous serial controller. A host addresses it through a 4-bit register select, an 8-bit write bus, a combinational read bus and single-cycle read and write strobes. The top select bit picks the channel. The low three bits pick one of that channel's registers: mode, status, command or data.

Each channel has two mode bytes that share one address. A mode pointer steps from the first byte to the second after one write and then stays there. A command byte turns the receiver and transmitter on or off, and its upper nibble runs an action such as a pointer reset or a receiver reset.

Received bytes arrive on a per-channel push port and wait in a four-slot ring that holds at most three bytes. The host drains the ring through the data register. A byte written to the data register leaves on a per-channel valid/data output, but only while that channel's transmitter is on. Bit-level serialisation, baud timing, timers, interrupts and parallel pins are handled elsewhere.

Top module: `dual_serial_regs`

## Requirements
- R1: Select bit 3 picks channel B when 1 and channel A when 0. Select bits 2:0 pick the register: 0 mode, 1 status, 2 command, 3 data. Reads of offsets 2 and 4 to 7 return 0x00, and writes to offsets 4 to 7 change nothing.
- R2: A mode write stores the byte at the current mode pointer. A pointer of 0 then moves to 1, and later writes keep landing in the second mode byte. A read of offset 0 returns the mode byte at the pointer. A command whose bits 7:4 equal 1 returns the pointer to 0.
- R3: Command bits 1:0 control the receiver and bits 3:2 control the transmitter. In each field 01 enables, 10 or 11 disables, and 00 leaves the state unchanged.
- R4: A data-register write while the transmitter is enabled raises that channel's tx_valid for exactly the next cycle, carrying the written byte. While the transmitter is disabled, the write produces no output.
- R5: While the receiver is enabled, each rx_push stores rx_byte in a ring that holds up to three bytes. Status bit 0 is 1 when the ring holds at least one byte. Status bit 1 is 1 when it holds three.
- R6: rx_push is ignored while the receiver is disabled.
- R7: A data-register read returns the oldest held byte and removes it. A read of an empty ring returns 0x00 and changes nothing.
- R8: A byte pushed into a full ring is discarded and sets status bit 4. The bit stays set until a command with action 4 (clear errors) or action 2 (receiver reset).
- R9: A command with action 2 empties the ring and disables the receiver. A command with action 3 disables the transmitter. Both take effect at the edge of the command write.
- R10: After reset, both channels have mode bytes 0, pointer 0, receiver and transmitter disabled and an empty ring, so status reads 0x00.
- R11: Status bits 2 and 3 both read 1 exactly while the transmitter is enabled. Bits 7:5 read 0. Actions 0 and 5 to 15 have no effect.
- R12: The two channels are independent. A write or push to one never changes the other's registers or outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 4 | Register select: bit 3 channel, bits 2:0 offset |
| wdata | input | 8 | Host write data |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| rdata | output | 8 | Read data, valid in the cycle of rd_en |
| tx_valid | output | 2 | Per-channel transmit byte valid (bit 0 = A) |
| tx_data | output | 16 | Per-channel transmit byte (7:0 = A) |
| rx_push | input | 2 | Per-channel received byte strobe |
| rx_byte | input | 16 | Per-channel received byte (7:0 = A) |

## Verification
The assertions assume that wr_en and rd_en are never high in the same cycle, and that sel is stable while a strobe is high. They also assume rx_push is a single-cycle pulse per byte. The bench follows these rules. Every access task raises a single strobe for exactly one clock edge with sel already settled, and the host tasks never overlap with a push.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int BYTE_W = 8;

  localparam logic [2:0] OFF_MODE = 3'd0;
  localparam logic [2:0] OFF_STAT = 3'd1;
  localparam logic [2:0] OFF_CMD  = 3'd2;
  localparam logic [2:0] OFF_DATA = 3'd3;

  localparam logic [3:0] ACT_PTR_RST = 4'd1;
  localparam logic [3:0] ACT_RX_RST  = 4'd2;
  localparam logic [3:0] ACT_TX_RST  = 4'd3;
  localparam logic [3:0] ACT_ERR_CLR = 4'd4;

  // two-bit on/off field: 00 keep, 01 on, anything else off
  function automatic logic enable_next(input logic [1:0] fld, input logic cur);
    return (fld == 2'b00) ? cur : (fld == 2'b01);
  endfunction

  function automatic logic [BYTE_W-1:0] status_pack(input logic rx_rdy, input logic full,
                                                    input logic tx_on, input logic ovr);
    return {3'b000, ovr, tx_on, tx_on, full, rx_rdy};
  endfunction
endpackage

// File: rtl/sreg_rx_queue.sv
module sreg_rx_queue #(
  parameter int DEPTH = 4,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full,
  output logic         drop
);
  localparam int IW = $clog2(DEPTH);

  logic [W-1:0]  slots [DEPTH];
  logic [IW-1:0] wr_idx, rd_idx;
  logic          accept, take;

  function automatic logic [IW-1:0] adv(input logic [IW-1:0] i);
    return (i == IW'(DEPTH-1)) ? '0 : i + 1'b1;
  endfunction

  assign empty  = (wr_idx == rd_idx);
  assign full   = (adv(wr_idx) == rd_idx);
  assign accept = push && !full;
  assign drop   = push && full;
  assign take   = pop && !empty;
  assign dout   = slots[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_idx <= '0;
      rd_idx <= '0;
    end else if (flush) begin
      wr_idx <= '0;
      rd_idx <= '0;
    end else begin
      if (accept) wr_idx <= adv(wr_idx);
      if (take)   rd_idx <= adv(rd_idx);
    end
  end

  always_ff @(posedge clk) begin
    if (accept && !flush) slots[wr_idx] <= din;
  end

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !flush) |=> $stable(wr_idx));

  // R7
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !flush && !push) |=> (empty && $stable(rd_idx)));
endmodule

// File: rtl/sreg_channel.sv
module sreg_channel
  import sreg_pkg::*;
#(
  parameter int W      = 8,
  parameter int OFF_W  = 3,
  parameter int QDEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic             rd_stb,
  input  logic [OFF_W-1:0] offs,
  input  logic [W-1:0]     wdata,
  output logic [W-1:0]     rdata,
  output logic             tx_valid,
  output logic [W-1:0]     tx_data,
  input  logic             rx_push,
  input  logic [W-1:0]     rx_byte
);
  logic [W-1:0] mode_r [2];
  logic         mode_ptr, rx_en, tx_en, ovr;

  // named events
  logic mode_wr, cmd_wr, data_wr, data_rd;
  logic ptr_rst, rx_rst, tx_rst, err_clr;
  logic [3:0] act;
  logic q_empty, q_full, q_drop;
  logic [W-1:0] q_head;

  assign mode_wr = wr_stb && (offs == OFF_W'(OFF_MODE));
  assign cmd_wr  = wr_stb && (offs == OFF_W'(OFF_CMD));
  assign data_wr = wr_stb && (offs == OFF_W'(OFF_DATA));
  assign data_rd = rd_stb && (offs == OFF_W'(OFF_DATA));
  assign act     = wdata[7:4];
  assign ptr_rst = cmd_wr && (act == ACT_PTR_RST);
  assign rx_rst  = cmd_wr && (act == ACT_RX_RST);
  assign tx_rst  = cmd_wr && (act == ACT_TX_RST);
  assign err_clr = cmd_wr && (act == ACT_ERR_CLR);

  sreg_rx_queue #(.DEPTH(QDEPTH), .W(W)) i_queue (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (rx_rst),
    .push  (rx_push && rx_en),
    .din   (rx_byte),
    .pop   (data_rd),
    .dout  (q_head),
    .empty (q_empty),
    .full  (q_full),
    .drop  (q_drop)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_r[0] <= '0;
      mode_r[1] <= '0;
      mode_ptr  <= 1'b0;
      rx_en     <= 1'b0;
      tx_en     <= 1'b0;
      ovr       <= 1'b0;
      tx_valid  <= 1'b0;
      tx_data   <= '0;
    end else begin
      if (mode_wr) begin
        mode_r[mode_ptr] <= wdata;
        mode_ptr         <= 1'b1;
      end
      if (cmd_wr) begin
        rx_en <= rx_rst ? 1'b0 : enable_next(wdata[1:0], rx_en);
        tx_en <= tx_rst ? 1'b0 : enable_next(wdata[3:2], tx_en);
        if (ptr_rst) mode_ptr <= 1'b0;
      end
      if (rx_rst || err_clr) ovr <= 1'b0;
      else if (q_drop)       ovr <= 1'b1;
      tx_valid <= data_wr && tx_en;
      if (data_wr && tx_en) tx_data <= wdata;
    end
  end

  always_comb begin
    unique case (offs)
      OFF_W'(OFF_MODE): rdata = mode_r[mode_ptr];
      OFF_W'(OFF_STAT): rdata = status_pack(!q_empty, q_full, tx_en, ovr);
      OFF_W'(OFF_DATA): rdata = q_empty ? '0 : q_head;
      default:          rdata = '0;
    endcase
  end

  // R4
  tx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !tx_en) |=> !tx_valid);

  // R2
  mode_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> mode_ptr);

  // R9
  rx_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rst |=> (q_empty && !rx_en && !ovr));

  // R8
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $past(q_drop));
endmodule

// File: rtl/dual_serial_regs.sv
module dual_serial_regs #(
  parameter int SEL_W  = 4,
  parameter int OFF_W  = 3,
  parameter int DATA_W = 8,
  parameter int QDEPTH = 4,
  parameter int NCH    = 1 << (SEL_W - OFF_W)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [SEL_W-1:0]      sel,
  input  logic [DATA_W-1:0]     wdata,
  input  logic                  wr_en,
  input  logic                  rd_en,
  output logic [DATA_W-1:0]     rdata,
  output logic [NCH-1:0]        tx_valid,
  output logic [NCH*DATA_W-1:0] tx_data,
  input  logic [NCH-1:0]        rx_push,
  input  logic [NCH*DATA_W-1:0] rx_byte
);
  localparam int CH_W = SEL_W - OFF_W;

  logic [CH_W-1:0]   ch_idx;
  logic [OFF_W-1:0]  offs;
  logic [DATA_W-1:0] ch_rdata [NCH];

  assign ch_idx = sel[SEL_W-1:OFF_W];
  assign offs   = sel[OFF_W-1:0];
  assign rdata  = ch_rdata[ch_idx];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic hit;
    assign hit = (ch_idx == CH_W'(g));

    sreg_channel #(.W(DATA_W), .OFF_W(OFF_W), .QDEPTH(QDEPTH)) i_channel (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_stb   (wr_en && hit),
      .rd_stb   (rd_en && hit),
      .offs     (offs),
      .wdata    (wdata),
      .rdata    (ch_rdata[g]),
      .tx_valid (tx_valid[g]),
      .tx_data  (tx_data[g*DATA_W +: DATA_W]),
      .rx_push  (rx_push[g]),
      .rx_byte  (rx_byte[g*DATA_W +: DATA_W])
    );
  end

  // R1
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && rd_en));
endmodule

// File: tb/test_dual_serial_regs.sv
module test_dual_serial_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  sel = '0;
  logic [7:0]  wdata = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  rdata;
  logic [1:0]  tx_valid;
  logic [15:0] tx_data;
  logic [1:0]  rx_push = '0;
  logic [15:0] rx_byte = '0;

  int compared = 0, mismatched = 0;
  logic [8:0] sb [$];

  always #10 clk = ~clk;

  dual_serial_regs i_dual_serial_regs (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wdata(wdata), .wr_en(wr_en), .rd_en(rd_en),
    .rdata(rdata), .tx_valid(tx_valid), .tx_data(tx_data), .rx_push(rx_push), .rx_byte(rx_byte)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); sel = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); #1 wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); sel = a; rd_en = 1'b1;
    #1 chk(rdata, exp, tag);
    @(posedge clk); #1 rd_en = 1'b0;
  endtask

  task automatic push(input int ch, input logic [7:0] d);
    @(negedge clk); rx_push[ch] = 1'b1; rx_byte[ch*8 +: 8] = d;
    @(posedge clk); #1 rx_push = '0;
  endtask

  task automatic send(input int ch, input logic [7:0] d);
    sb.push_back({ch[0], d});
    wr(ch == 0 ? 4'd3 : 4'd11, d);
  endtask

  // scoreboard monitor (R4, R12)
  always @(negedge clk) begin
    if (rst_n) begin
      for (int c = 0; c < 2; c++) begin
        if (tx_valid[c]) begin
          if (sb.size() == 0) begin
            compared++; mismatched++;
            $display("FAIL R4: unexpected tx on ch%0d got %02h expected none", c, tx_data[c*8 +: 8]);
          end else begin
            logic [8:0] e;
            e = sb.pop_front();
            chk({7'd0, c[0]}, {7'd0, e[8]}, "R12 tx channel");
            chk(tx_data[c*8 +: 8], e[7:0], "R4 tx byte");
          end
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    compared++; mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #45 rst_n = 1'b1;
    // R10 reset state
    rd_chk(4'd1, 8'h00, "R10 status A");
    rd_chk(4'd9, 8'h00, "R10 status B");
    rd_chk(4'd0, 8'h00, "R10 mode A");
    rd_chk(4'd3, 8'h00, "R10 data A empty");
    // R2 mode pointer
    wr(4'd0, 8'h11);
    rd_chk(4'd0, 8'h00, "R2 pointer moved to second");
    wr(4'd0, 8'h22);
    wr(4'd0, 8'h33);
    rd_chk(4'd0, 8'h33, "R2 second byte sticks");
    wr(4'd2, 8'h10);
    rd_chk(4'd0, 8'h11, "R2 pointer reset");
    rd_chk(4'd8, 8'h00, "R12 mode B untouched");
    // R4 gated transmit
    wr(4'd3, 8'hE1);
    wr(4'd2, 8'h04);
    rd_chk(4'd1, 8'h0C, "R11 tx on status");
    send(0, 8'h5A);
    send(0, 8'hA5);
    wr(4'd11, 8'hB0);
    rd_chk(4'd9, 8'h00, "R12 status B");
    // R6 push while rx disabled
    push(0, 8'h99);
    rd_chk(4'd1, 8'h0C, "R6 ignored push");
    // R5 queue fill
    wr(4'd2, 8'h01);
    push(0, 8'hA1); push(0, 8'hA2);
    rd_chk(4'd1, 8'h0D, "R5 ready not full");
    push(0, 8'hA3);
    rd_chk(4'd1, 8'h0F, "R5 full at three");
    rd_chk(4'd9, 8'h00, "R12 B unaffected by A push");
    // R8 overrun
    push(0, 8'hA4);
    rd_chk(4'd1, 8'h1F, "R8 overrun set");
    rd_chk(4'd3, 8'hA1, "R7 oldest first");
    rd_chk(4'd3, 8'hA2, "R7 second");
    rd_chk(4'd1, 8'h1D, "R8 overrun held");
    wr(4'd2, 8'h40);
    rd_chk(4'd1, 8'h0D, "R8 cleared by action 4");
    rd_chk(4'd3, 8'hA3, "R7 third, dropped byte absent");
    rd_chk(4'd3, 8'h00, "R7 empty read");
    rd_chk(4'd1, 8'h0C, "R7 empty status");
    push(0, 8'hB1);
    rd_chk(4'd3, 8'hB1, "R7 indices unchanged by empty read");
    // R9 resets
    push(0, 8'hC1);
    wr(4'd2, 8'h21);
    rd_chk(4'd1, 8'h0C, "R9 rx reset empties");
    push(0, 8'hC2);
    rd_chk(4'd1, 8'h0C, "R9 rx disabled after reset");
    wr(4'd2, 8'h30);
    rd_chk(4'd1, 8'h00, "R9 tx reset");
    wr(4'd3, 8'hE2);
    // R3 field encodings on B
    wr(4'd10, 8'h04);
    send(1, 8'h77);
    wr(4'd10, 8'h0C);
    rd_chk(4'd9, 8'h00, "R3 field 11 disables");
    wr(4'd10, 8'h04);
    wr(4'd10, 8'h08);
    rd_chk(4'd9, 8'h00, "R3 field 10 disables");
    wr(4'd10, 8'h04);
    wr(4'd10, 8'h60);
    wr(4'd10, 8'h50);
    wr(4'd10, 8'hF0);
    rd_chk(4'd9, 8'h0C, "R11 inert actions, R3 field 00 keeps");
    // R8 cleared by receiver reset on B
    wr(4'd10, 8'h01);
    for (int i = 0; i < 4; i++) push(1, 8'(8'hD0 + i));
    rd_chk(4'd9, 8'h1F, "R8 overrun on B");
    rd_chk(4'd1, 8'h00, "R12 A unaffected");
    wr(4'd10, 8'h20);
    rd_chk(4'd9, 8'h0C, "R8 cleared by rx reset");
    // R1 unused offsets
    wr(4'd4, 8'hFF);
    wr(4'd15, 8'hFF);
    rd_chk(4'd4, 8'h00, "R1 offset 4");
    rd_chk(4'd15, 8'h00, "R1 offset 7");
    rd_chk(4'd2, 8'h00, "R1 command reads 0");
    rd_chk(4'd9, 8'h0C, "R1 unused writes inert");
    repeat (3) @(negedge clk);
    chk(8'(sb.size()), 8'h00, "R4 all expected bytes sent");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule